// File: doc/BRIEF.md
# Per-Channel Fault Recovery Controller

This block decides, separately for each channel of a multi-channel switching regulator, what happens after a protection event. It reacts to three events: an over-temperature shutdown, a high-side switch current limit and a low-side switch current limit. When one fires, the block drives the channel's switch override commands and discharges the compensation node. It then either holds the channel off for good or brings it back through a soft-start.

A per-channel, per-event configuration bit selects how a fault is handled. When the bit is set, the fault is latched: the channel stays off until software clears the fault record and then enables the channel again with a fresh low-to-high step. When the bit is clear, the channel restarts by itself. For an over-temperature fault, the restart waits for a "cooled down" input. For a current-limit fault, it waits for a programmable delay counted in ticks. Every restart passes through a soft-start phase of fixed length before normal switching resumes. The analog sensing and the PWM loop sit outside this block. The block only produces the override commands and the soft-start request.

Each channel has five states: disabled, running, waiting after a fault, soft-starting and latched. The tick input sets the time base. `BASE_TICKS` ticks make up the shortest current-limit delay, and the default values give 3.6 ms with a 100 µs tick.

Top module: `fault_recovery_ctrl`

## Requirements
- R1: After reset, with enables low, every channel outputs hs_off=1, ls_on=0, ls_off=1, comp_dis=1, ss_req=0.
- R2: A channel that is disabled and sees its enable high enters soft-start on the next clock edge: ss_req=1, all override outputs 0, for exactly SS_CYCLES cycles, then all five outputs are 0 (running). Enable low in any non-latched state returns the disabled outputs of R1 on the next edge.
- R3: An unlatched high-side current-limit event in running or soft-start gives hs_off=1, ls_on=1, ls_off=0, comp_dis=1, ss_req=0 from the next edge.
- R4: An unlatched low-side current-limit event gives hs_off=1, ls_on=0, ls_off=1, comp_dis=1, ss_req=0 from the next edge.
- R5: An unlatched thermal event drives the outputs of R4. The channel holds them while ts_recovered is low, and enters soft-start on the edge after ts_recovered is seen high.
- R6: An unlatched current-limit wait lasts BASE_TICKS << code ticks, where code is ift_sel (0 to 3, a doubling per step) as sampled on the edge that starts the wait. Later changes of ift_sel do not alter a running wait.
- R7: Simultaneous events are resolved with the priority thermal > low-side > high-side, and the winner sets both the switch mode and the wait.
- R8: A fault whose latch bit is set moves the channel to a latched state with the outputs of R4. Re-enabling alone does not release it. Only a status_clr pulse, followed by enable going from low to high, starts soft-start.
- R9: A fault during soft-start aborts it and begins a new wait of full length, using the ift_sel value at that edge.
- R10: Channels are independent: events, enables and configuration of one channel never change another channel's outputs.
- R11: Fault events that arrive while a channel is waiting or latched are ignored. They do not change the switch mode or the wait length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base strobe for current-limit waits |
| ift_sel | input | 2 | Current-limit wait code (0..3) |
| ch_en | input | NUM_CH | Channel enable |
| ts_evt | input | NUM_CH | Over-temperature shutdown event |
| hs_ilim | input | NUM_CH | High-side current-limit event |
| ls_ilim | input | NUM_CH | Low-side current-limit event |
| ts_recovered | input | NUM_CH | Temperature has fallen back past the hysteresis |
| latch_ts | input | NUM_CH | Latch-off select for thermal faults |
| latch_hs | input | NUM_CH | Latch-off select for high-side limit faults |
| latch_ls | input | NUM_CH | Latch-off select for low-side limit faults |
| status_clr | input | NUM_CH | Pulse that clears the latched fault record |
| hs_off | output | NUM_CH | Force high-side switch off |
| ls_on | output | NUM_CH | Force low-side switch on |
| ls_off | output | NUM_CH | Force low-side switch off |
| comp_dis | output | NUM_CH | Discharge the compensation node |
| ss_req | output | NUM_CH | Soft-start request |

## Verification
The bench targets cases that are easy to get wrong:
- **Wait code sampling.** It changes ift_sel in the middle of a wait. A design that reads the code live would end the wait after the wrong number of ticks.
- **Fault during soft-start.** It injects a fault while soft-start is running. A design that does not restart the timer would resume switching too early.
- **Simultaneous events.** It fires several events in the same cycle. A wrong priority shows up as the wrong switch mode or the wrong recovery path.
- **Latched release.** It re-enables a latched channel without the clear pulse. A design that ignores the clear would restart on that enable edge.
- **Events in the wrong state.** It fires events during waits, which must be ignored.
- **Channel isolation.** It sends traffic to one channel while watching the other for any disturbance.

// File: rtl/frc_pkg.sv
package frc_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_RUN,
    ST_WAIT,
    ST_SOFT,
    ST_LATCH
  } ch_state_t;

  typedef enum logic [1:0] {
    FK_NONE,
    FK_THERM,
    FK_HS,
    FK_LS
  } fault_kind_t;

  typedef struct packed {
    logic hs_off;
    logic ls_on;
    logic ls_off;
    logic comp_dis;
    logic ss_req;
  } drv_cmd_t;

  // Output command for a given state and recorded fault kind
  function automatic drv_cmd_t cmd_for(ch_state_t s, fault_kind_t k);
    drv_cmd_t c;
    c = '{hs_off: 1'b1, ls_on: 1'b0, ls_off: 1'b1, comp_dis: 1'b1, ss_req: 1'b0};
    case (s)
      ST_RUN:  c = '{hs_off: 1'b0, ls_on: 1'b0, ls_off: 1'b0, comp_dis: 1'b0, ss_req: 1'b0};
      ST_SOFT: c = '{hs_off: 1'b0, ls_on: 1'b0, ls_off: 1'b0, comp_dis: 1'b0, ss_req: 1'b1};
      ST_WAIT: begin
        if (k == FK_HS)
          c = '{hs_off: 1'b1, ls_on: 1'b1, ls_off: 1'b0, comp_dis: 1'b1, ss_req: 1'b0};
      end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/frc_fault_arbiter.sv
module frc_fault_arbiter
  import frc_pkg::*;
(
  input  logic        ts_evt,
  input  logic        hs_evt,
  input  logic        ls_evt,
  input  logic        lat_ts,
  input  logic        lat_hs,
  input  logic        lat_ls,
  output fault_kind_t kind,
  output logic        latch
);

  // Priority: thermal, then low-side, then high-side
  always_comb begin
    kind  = FK_NONE;
    latch = 1'b0;
    if (ts_evt) begin
      kind  = FK_THERM;
      latch = lat_ts;
    end else if (ls_evt) begin
      kind  = FK_LS;
      latch = lat_ls;
    end else if (hs_evt) begin
      kind  = FK_HS;
      latch = lat_hs;
    end
  end

endmodule

// File: rtl/frc_retry_timer.sv
module frc_retry_timer #(
  parameter int BASE_TICKS = 36
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [1:0] sel_in,
  input  logic       run,
  input  logic       tick,
  output logic       expire
);

  localparam int MAX_TICKS = BASE_TICKS * 8;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic [1:0]       sel_q;

  assign lim    = CNT_W'(BASE_TICKS) << sel_q;
  assign expire = run && tick && (cnt == lim - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      sel_q <= '0;
    end else if (load) begin
      cnt   <= '0;
      sel_q <= sel_in;
    end else if (run && tick) begin
      cnt <= expire ? '0 : cnt + CNT_W'(1);
    end
  end

  a_r6_count_in_window: assert property (@(posedge clk) disable iff (rst)
    cnt < lim);

endmodule

// File: rtl/frc_softstart_cnt.sv
module frc_softstart_cnt #(
  parameter int SS_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic done
);

  localparam int SS_W = $clog2(SS_CYCLES + 1);

  logic [SS_W-1:0] cnt;

  assign done = run && (cnt == SS_W'(SS_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst || load) cnt <= '0;
    else if (run && !done) cnt <= cnt + SS_W'(1);
  end

  a_r2_ss_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt < SS_W'(SS_CYCLES));

endmodule

// File: rtl/frc_channel.sv
module frc_channel
  import frc_pkg::*;
#(
  parameter int BASE_TICKS = 36,
  parameter int SS_CYCLES  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [1:0] ift_sel,
  input  logic       en,
  input  logic       ts_evt,
  input  logic       hs_evt,
  input  logic       ls_evt,
  input  logic       ts_rec,
  input  logic       lat_ts,
  input  logic       lat_hs,
  input  logic       lat_ls,
  input  logic       stat_clr,
  output drv_cmd_t   cmd
);

  ch_state_t   st, nxt;
  fault_kind_t kind_q, nkind, arb_kind;
  logic        arb_latch;
  logic        clr_seen, en_q;
  logic        tmr_load, tmr_run, tmr_exp;
  logic        ss_load, ss_run, ss_done;
  drv_cmd_t    cmd_q;

  frc_fault_arbiter u_arb (
    .ts_evt (ts_evt),
    .hs_evt (hs_evt),
    .ls_evt (ls_evt),
    .lat_ts (lat_ts),
    .lat_hs (lat_hs),
    .lat_ls (lat_ls),
    .kind   (arb_kind),
    .latch  (arb_latch)
  );

  frc_retry_timer #(.BASE_TICKS(BASE_TICKS)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .load   (tmr_load),
    .sel_in (ift_sel),
    .run    (tmr_run),
    .tick   (tick),
    .expire (tmr_exp)
  );

  frc_softstart_cnt #(.SS_CYCLES(SS_CYCLES)) u_ss (
    .clk  (clk),
    .rst  (rst),
    .load (ss_load),
    .run  (ss_run),
    .done (ss_done)
  );

  always_comb begin
    nxt   = st;
    nkind = kind_q;
    case (st)
      ST_OFF: if (en) nxt = ST_SOFT;
      ST_RUN, ST_SOFT: begin
        if (!en) begin
          nxt = ST_OFF;
        end else if (arb_kind != FK_NONE) begin
          nkind = arb_kind;
          nxt   = arb_latch ? ST_LATCH : ST_WAIT;
        end else if (st == ST_SOFT && ss_done) begin
          nxt = ST_RUN;
        end
      end
      ST_WAIT: begin
        if (!en) nxt = ST_OFF;
        else if (kind_q == FK_THERM ? ts_rec : tmr_exp) nxt = ST_SOFT;
      end
      ST_LATCH: if (clr_seen && en && !en_q) nxt = ST_SOFT;
      default: nxt = ST_OFF;
    endcase
  end

  assign tmr_load = (nxt == ST_WAIT) && (st != ST_WAIT);
  assign tmr_run  = (st == ST_WAIT) && (kind_q != FK_THERM);
  assign ss_load  = (nxt == ST_SOFT) && (st != ST_SOFT);
  assign ss_run   = (st == ST_SOFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_OFF;
      kind_q   <= FK_NONE;
      clr_seen <= 1'b0;
      en_q     <= 1'b0;
      cmd_q    <= cmd_for(ST_OFF, FK_NONE);
    end else begin
      st     <= nxt;
      kind_q <= nkind;
      en_q   <= en;
      cmd_q  <= cmd_for(nxt, nkind);
      if (st != ST_LATCH) clr_seen <= 1'b0;
      else if (stat_clr)  clr_seen <= 1'b1;
    end
  end

  assign cmd = cmd_q;

  a_r2_disable_off: assert property (@(posedge clk) disable iff (rst)
    (!en && st != ST_LATCH) |=> (cmd_q.hs_off && cmd_q.ls_off && cmd_q.comp_dis));

  a_r3_hs_limit_mode: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_RUN || st == ST_SOFT) && en && hs_evt && !ts_evt && !ls_evt && !lat_hs)
    |=> (cmd_q.hs_off && cmd_q.ls_on && !cmd_q.ls_off && cmd_q.comp_dis));

  a_r4_ls_limit_mode: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_RUN || st == ST_SOFT) && en && ls_evt && !ts_evt && !lat_ls)
    |=> (cmd_q.hs_off && !cmd_q.ls_on && cmd_q.ls_off && cmd_q.comp_dis));

  a_r5_thermal_hold: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && kind_q == FK_THERM && !ts_rec && en) |=> (st == ST_WAIT));

  a_r8_latch_hold: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LATCH && !clr_seen) |=> (st == ST_LATCH));

  a_r9_soft_abort: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SOFT && en && (ts_evt || hs_evt || ls_evt)) |=> (st != ST_RUN && !cmd_q.ss_req));

endmodule

// File: rtl/fault_recovery_ctrl.sv
module fault_recovery_ctrl
  import frc_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int BASE_TICKS = 36,
  parameter int SS_CYCLES  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [1:0]        ift_sel,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] ts_evt,
  input  logic [NUM_CH-1:0] hs_ilim,
  input  logic [NUM_CH-1:0] ls_ilim,
  input  logic [NUM_CH-1:0] ts_recovered,
  input  logic [NUM_CH-1:0] latch_ts,
  input  logic [NUM_CH-1:0] latch_hs,
  input  logic [NUM_CH-1:0] latch_ls,
  input  logic [NUM_CH-1:0] status_clr,
  output logic [NUM_CH-1:0] hs_off,
  output logic [NUM_CH-1:0] ls_on,
  output logic [NUM_CH-1:0] ls_off,
  output logic [NUM_CH-1:0] comp_dis,
  output logic [NUM_CH-1:0] ss_req
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    drv_cmd_t c;

    frc_channel #(
      .BASE_TICKS (BASE_TICKS),
      .SS_CYCLES  (SS_CYCLES)
    ) u_ch (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .ift_sel  (ift_sel),
      .en       (ch_en[g]),
      .ts_evt   (ts_evt[g]),
      .hs_evt   (hs_ilim[g]),
      .ls_evt   (ls_ilim[g]),
      .ts_rec   (ts_recovered[g]),
      .lat_ts   (latch_ts[g]),
      .lat_hs   (latch_hs[g]),
      .lat_ls   (latch_ls[g]),
      .stat_clr (status_clr[g]),
      .cmd      (c)
    );

    assign hs_off[g]   = c.hs_off;
    assign ls_on[g]    = c.ls_on;
    assign ls_off[g]   = c.ls_off;
    assign comp_dis[g] = c.comp_dis;
    assign ss_req[g]   = c.ss_req;
  end

endmodule

// File: tb/fault_recovery_ctrl_test.sv
module fault_recovery_ctrl_test;

  localparam int NCH = 2;
  localparam int BT  = 2;
  localparam int SSC = 4;

  localparam logic [4:0] V_OFF = 5'b10110;
  localparam logic [4:0] V_RUN = 5'b00000;
  localparam logic [4:0] V_SS  = 5'b00001;
  localparam logic [4:0] V_HSW = 5'b11010;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic [1:0] ift_sel = 2'd0;
  logic [NCH-1:0] ch_en = '0, ts_evt = '0, hs_ilim = '0, ls_ilim = '0, ts_recovered = '0;
  logic [NCH-1:0] latch_ts = '0, latch_hs = '0, latch_ls = '0, status_clr = '0;
  logic [NCH-1:0] hs_off, ls_on, ls_off, comp_dis, ss_req;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  typedef struct {
    int         at;
    int         ch;
    logic [4:0] v;
    string      req;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fault_recovery_ctrl #(.NUM_CH(NCH), .BASE_TICKS(BT), .SS_CYCLES(SSC)) uut (
    .clk(clk), .rst(rst), .tick(tick), .ift_sel(ift_sel), .ch_en(ch_en),
    .ts_evt(ts_evt), .hs_ilim(hs_ilim), .ls_ilim(ls_ilim), .ts_recovered(ts_recovered),
    .latch_ts(latch_ts), .latch_hs(latch_hs), .latch_ls(latch_ls), .status_clr(status_clr),
    .hs_off(hs_off), .ls_on(ls_on), .ls_off(ls_off), .comp_dis(comp_dis), .ss_req(ss_req)
  );

  // Driver side: expected output for channel ch at cycles cyc+from .. cyc+to
  task automatic expect_span(int ch, logic [4:0] v, int from, int to, string req);
    for (int k = from; k <= to; k++) begin
      exp_t e;
      e.at = cyc + k; e.ch = ch; e.v = v; e.req = req;
      q.push_back(e);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare every expectation due this cycle
  initial begin
    forever begin
      @(negedge clk);
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].at == cyc) begin
          logic [4:0] obs;
          int c;
          c = q[i].ch;
          obs = {hs_off[c], ls_on[c], ls_off[c], comp_dis[c], ss_req[c]};
          n_chk++;
          if (obs !== q[i].v) begin
            n_fail++;
            $display("FAIL %s ch%0d cyc %0d: actual %b expected %b", q[i].req, c, cyc, obs, q[i].v);
          end
          q.delete(i);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state on both channels
    expect_span(0, V_OFF, 1, 2, "R1");
    expect_span(1, V_OFF, 1, 2, "R1");
    idle(3);

    // R2: enable -> soft-start of SSC cycles -> run
    ch_en[0] = 1'b1;
    expect_span(0, V_SS, 1, 4, "R2");
    expect_span(0, V_RUN, 5, 5, "R2");
    idle(6);

    // R3: high-side limit, code 0 -> 2-tick wait
    ift_sel = 2'd0; hs_ilim[0] = 1'b1;
    expect_span(0, V_HSW, 1, 2, "R3");
    expect_span(0, V_SS, 3, 6, "R3");
    expect_span(0, V_RUN, 7, 7, "R3");
    idle(1); hs_ilim[0] = 1'b0;
    idle(7);

    // R4 + R6 capture + R11: low-side limit code 1 (4 ticks); code changed and hs event mid-wait
    ift_sel = 2'd1; ls_ilim[0] = 1'b1;
    expect_span(0, V_OFF, 1, 4, "R4/R6/R11");
    expect_span(0, V_SS, 5, 8, "R6");
    expect_span(0, V_RUN, 9, 9, "R6");
    idle(1); ls_ilim[0] = 1'b0; ift_sel = 2'd3;
    idle(1); hs_ilim[0] = 1'b1;
    idle(1); hs_ilim[0] = 1'b0;
    idle(7);

    // R6: code 2 -> 8 ticks
    ift_sel = 2'd2; hs_ilim[0] = 1'b1;
    expect_span(0, V_HSW, 1, 8, "R6");
    expect_span(0, V_SS, 9, 12, "R6");
    expect_span(0, V_RUN, 13, 13, "R6");
    idle(1); hs_ilim[0] = 1'b0;
    idle(13);

    // R6: code 3 -> 16 ticks
    ift_sel = 2'd3; ls_ilim[0] = 1'b1;
    expect_span(0, V_OFF, 1, 16, "R6");
    expect_span(0, V_SS, 17, 20, "R6");
    expect_span(0, V_RUN, 21, 21, "R6");
    idle(1); ls_ilim[0] = 1'b0;
    idle(21);

    // R5: thermal wait held until recovered input
    ts_evt[0] = 1'b1;
    expect_span(0, V_OFF, 1, 6, "R5");
    expect_span(0, V_SS, 7, 10, "R5");
    expect_span(0, V_RUN, 11, 11, "R5");
    idle(1); ts_evt[0] = 1'b0;
    idle(5); ts_recovered[0] = 1'b1;
    idle(1); ts_recovered[0] = 1'b0;
    idle(5);

    // R7: thermal beats high-side (recovered already high -> quick restart)
    ts_recovered[0] = 1'b1; ts_evt[0] = 1'b1; hs_ilim[0] = 1'b1;
    expect_span(0, V_OFF, 1, 1, "R7");
    expect_span(0, V_SS, 2, 5, "R7");
    expect_span(0, V_RUN, 6, 6, "R7");
    idle(1); ts_evt[0] = 1'b0; hs_ilim[0] = 1'b0;
    idle(1); ts_recovered[0] = 1'b0;
    idle(5);

    // R7: low-side beats high-side
    ift_sel = 2'd0; ls_ilim[0] = 1'b1; hs_ilim[0] = 1'b1;
    expect_span(0, V_OFF, 1, 2, "R7");
    expect_span(0, V_SS, 3, 6, "R7");
    expect_span(0, V_RUN, 7, 7, "R7");
    idle(1); ls_ilim[0] = 1'b0; hs_ilim[0] = 1'b0;
    idle(7);

    // R9: fault in soft-start restarts a full wait with the new code
    hs_ilim[0] = 1'b1;
    expect_span(0, V_HSW, 1, 2, "R9");
    expect_span(0, V_SS, 3, 4, "R9");
    expect_span(0, V_OFF, 5, 8, "R9");
    expect_span(0, V_SS, 9, 12, "R9");
    expect_span(0, V_RUN, 13, 13, "R9");
    idle(1); hs_ilim[0] = 1'b0;
    idle(3); ls_ilim[0] = 1'b1; ift_sel = 2'd1;
    idle(1); ls_ilim[0] = 1'b0; ift_sel = 2'd0;
    idle(9);

    // R8: latched fault; re-enable without clear ignored; clear then rising enable restarts
    latch_hs[0] = 1'b1; hs_ilim[0] = 1'b1;
    expect_span(0, V_OFF, 1, 11, "R8");
    expect_span(0, V_SS, 12, 15, "R8");
    expect_span(0, V_RUN, 16, 16, "R8");
    idle(1); hs_ilim[0] = 1'b0;
    idle(1); ts_evt[0] = 1'b1;            // R11: ignored while latched
    idle(1); ts_evt[0] = 1'b0; ch_en[0] = 1'b0;
    idle(2); ch_en[0] = 1'b1;
    idle(3); status_clr[0] = 1'b1;
    idle(1); status_clr[0] = 1'b0; ch_en[0] = 1'b0;
    idle(2); ch_en[0] = 1'b1; latch_hs[0] = 1'b0;
    idle(6);

    // R10: channel 1 activity leaves channel 0 running
    ch_en[1] = 1'b1;
    expect_span(1, V_SS, 1, 4, "R10");
    expect_span(1, V_RUN, 5, 5, "R10");
    expect_span(0, V_RUN, 1, 13, "R10");
    idle(6); hs_ilim[1] = 1'b1;
    expect_span(1, V_HSW, 1, 2, "R10");
    expect_span(1, V_SS, 3, 6, "R10");
    expect_span(1, V_RUN, 7, 7, "R10");
    idle(1); hs_ilim[1] = 1'b0;
    idle(7);

    // R2: disable returns the off state
    ch_en[0] = 1'b0;
    expect_span(0, V_OFF, 1, 2, "R2");
    expect_span(1, V_RUN, 1, 2, "R10");
    idle(4);

    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule